// File: doc/BRIEF.md
# Register-Mapped GPIO Port with Atomic Set and Clear

This block is a general-purpose I/O port of WIDTH pins sitting behind a minimal register bus: a two-bit word address, a write strobe, write data and a combinational read data word. Software drives the pins through an output latch, which it can load whole or change bit by bit through write-one-to-set and write-one-to-clear registers. A direction register decides which pins are driven.

Three elaboration-time options shape the port. The polarity of the direction register can be chosen so that a 1 marks an output or so that a 1 marks an input. The pin order inside every register word can be normal (pin n at bit n) or mirrored (pin n at bit WIDTH-1-n). The clear register can be left out, in which case the set register acts as a second full-word load. Input pins cross into the clock domain through a two-flop synchroniser before they can be read.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset every output bit is 0, every pin is an input (pin_oe all 0), and the direction register reads all 0 when a 1 marks an output, all 1 when a 1 marks an input.
- R2: A write to word address 0 (data) loads the whole output latch; pin_out shows the new value after the clock edge that accepts the write, and the latch holds when no output-affecting write occurs.
- R3: A write to word address 1 (set), with the clear register present, turns on the output bits whose written bit is 1 and leaves the others unchanged.
- R4: A write to word address 2 (clear) turns off the output bits whose written bit is 1 and leaves the others unchanged.
- R5: A write to word address 3 (direction) sets pin_oe: with DIR_ONE_IS_OUT=1 a 1 bit enables the driver, with DIR_ONE_IS_OUT=0 a 1 bit disables it; reading address 3 returns the stored word.
- R6: Reading address 0 returns, per pin, the driven output value if the pin is an output and the synchronised input value if it is an input.
- R7: A change on pin_in reaches the address-0 read value after exactly two clock edges; after one edge the old value is still read.
- R8: With MIRROR=1, pin n corresponds to register bit WIDTH-1-n in every register (data, set, clear, direction, read-back); with MIRROR=0 pin n is bit n.
- R9: With HAS_CLEAR=0, a write to address 1 loads the whole output latch as a data write does, and a write to address 2 has no effect.
- R10: Reading address 1 or address 2 returns the current output latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Word address: 0 data, 1 set, 2 clear, 3 direction |
| bus_we | input | 1 | Write strobe, write accepted on the rising edge |
| bus_wdata | input | WIDTH | Write data in register bit order |
| bus_rdata | output | WIDTH | Read data for bus_addr, combinational |
| pin_in | input | WIDTH | Asynchronous pad inputs |
| pin_out | output | WIDTH | Output values per pin |
| pin_oe | output | WIDTH | Output enable per pin |

## Verification
The bench goes after the set and clear registers with zero masks and full masks, where a design that wrote the mask straight into the latch would wipe bits it should keep. It samples the read path one edge and two edges after an input change, catching a synchroniser that is one flop short or absent, and it reads pins that are inputs while their latch bit differs, exposing a read path that returns the latch instead of the pad. A second instance with mirrored order, inverted direction polarity and no clear register shows bit reversal errors as swapped pins, a wrong reset direction as pins that drive out of reset, and a clear write that still acts as a changed output.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int MAX_W = 64;

  typedef enum logic [1:0] {
    ADDR_DATA = 2'd0,
    ADDR_SET  = 2'd1,
    ADDR_CLR  = 2'd2,
    ADDR_DIR  = 2'd3
  } gpio_addr_e;

  // Map between register bit order and pin order; the mapping is its own inverse.
  function automatic logic [MAX_W-1:0] reorder(input logic [MAX_W-1:0] v,
                                               input int w, input bit mir);
    logic [MAX_W-1:0] r;
    r = '0;
    for (int i = 0; i < MAX_W; i++) begin
      if (i < w) r[i] = mir ? v[w-1-i] : v[i];
    end
    return r;
  endfunction

  // Next output latch value for an accepted write (pin order).
  function automatic logic [MAX_W-1:0] apply_write(input logic [MAX_W-1:0] cur,
                                                   input logic [MAX_W-1:0] val,
                                                   input logic [1:0] addr,
                                                   input bit has_clear);
    logic [MAX_W-1:0] r;
    case (addr)
      ADDR_DATA: r = val;
      ADDR_SET:  r = has_clear ? (cur | val) : val;
      ADDR_CLR:  r = has_clear ? (cur & ~val) : cur;
      default:   r = cur;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int W              = 32,
  parameter bit DIR_ONE_IS_OUT = 1'b1,
  parameter bit HAS_CLEAR      = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         out_wr,
  input  logic         dir_wr,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_pin,
  output logic [W-1:0] out_q,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] oe
);
  import gpio_port_pkg::*;

  localparam logic [W-1:0] DIR_RST = DIR_ONE_IS_OUT ? '0 : '1;

  logic [W-1:0] out_next;

  always_comb begin
    out_next = W'(apply_write(MAX_W'(out_q), MAX_W'(wr_pin), wr_addr, HAS_CLEAR));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      dir_q <= DIR_RST;
    end else begin
      if (out_wr) out_q <= out_next;
      if (dir_wr) dir_q <= wr_pin;
    end
  end

  generate
    if (DIR_ONE_IS_OUT) begin : g_dir_out
      assign oe = dir_q;
    end else begin : g_dir_in
      assign oe = ~dir_q;
    end
  endgenerate
endmodule

// File: rtl/gpio_port_readmux.sv
module gpio_port_readmux #(
  parameter int W      = 32,
  parameter bit MIRROR = 1'b0
) (
  input  logic [1:0]   rd_addr,
  input  logic [W-1:0] out_q,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] oe,
  input  logic [W-1:0] in_sync,
  output logic [W-1:0] rdata
);
  import gpio_port_pkg::*;

  logic [W-1:0] pin_view;
  logic [W-1:0] sel_pin;

  assign pin_view = (oe & out_q) | (~oe & in_sync);

  always_comb begin
    case (rd_addr)
      ADDR_DATA: sel_pin = pin_view;
      ADDR_DIR:  sel_pin = dir_q;
      default:   sel_pin = out_q;
    endcase
    rdata = W'(reorder(MAX_W'(sel_pin), W, MIRROR));
  end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl #(
  parameter int WIDTH          = 32,
  parameter bit DIR_ONE_IS_OUT = 1'b1,
  parameter bit MIRROR         = 1'b0,
  parameter bit HAS_CLEAR      = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       bus_addr,
  input  logic             bus_we,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic [WIDTH-1:0] pin_in,
  output logic [WIDTH-1:0] pin_out,
  output logic [WIDTH-1:0] pin_oe
);
  import gpio_port_pkg::*;

  // Named internal events
  logic             data_wr;
  logic             set_wr;
  logic             clr_wr;
  logic             dir_wr;
  logic             out_wr;
  logic [WIDTH-1:0] wr_pin;
  logic [WIDTH-1:0] out_q;
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] oe;
  logic [WIDTH-1:0] in_sync;

  assign data_wr = bus_we && (bus_addr == ADDR_DATA);
  assign set_wr  = bus_we && (bus_addr == ADDR_SET);
  assign clr_wr  = bus_we && (bus_addr == ADDR_CLR) && HAS_CLEAR;
  assign dir_wr  = bus_we && (bus_addr == ADDR_DIR);
  assign out_wr  = data_wr || set_wr || clr_wr;
  assign wr_pin  = WIDTH'(reorder(MAX_W'(bus_wdata), WIDTH, MIRROR));

  gpio_port_sync #(.W(WIDTH)) sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_in(pin_in),
    .sync_out(in_sync)
  );

  gpio_port_regs #(
    .W             (WIDTH),
    .DIR_ONE_IS_OUT(DIR_ONE_IS_OUT),
    .HAS_CLEAR     (HAS_CLEAR)
  ) regs_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .out_wr (out_wr),
    .dir_wr (dir_wr),
    .wr_addr(bus_addr),
    .wr_pin (wr_pin),
    .out_q  (out_q),
    .dir_q  (dir_q),
    .oe     (oe)
  );

  gpio_port_readmux #(.W(WIDTH), .MIRROR(MIRROR)) rmux_i (
    .rd_addr(bus_addr),
    .out_q  (out_q),
    .dir_q  (dir_q),
    .oe     (oe),
    .in_sync(in_sync),
    .rdata  (bus_rdata)
  );

  assign pin_out = out_q;
  assign pin_oe  = oe;
endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk #(
  parameter int WIDTH          = 32,
  parameter bit DIR_ONE_IS_OUT = 1'b1,
  parameter bit MIRROR         = 1'b0,
  parameter bit HAS_CLEAR      = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       bus_addr,
  input logic             bus_we,
  input logic [WIDTH-1:0] bus_wdata,
  input logic [WIDTH-1:0] bus_rdata,
  input logic [WIDTH-1:0] pin_out,
  input logic [WIDTH-1:0] pin_oe
);
  import gpio_port_pkg::*;

  logic [WIDTH-1:0] w_pin;
  logic [WIDTH-1:0] rd_pin;
  assign w_pin  = WIDTH'(reorder(MAX_W'(bus_wdata), WIDTH, MIRROR));
  assign rd_pin = WIDTH'(reorder(MAX_W'(bus_rdata), WIDTH, MIRROR));

  AST_SET_ONLY_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_SET && HAS_CLEAR) |=> (pin_out == ($past(pin_out) | $past(w_pin)))); // R3
  AST_CLR_ONLY_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_CLR && HAS_CLEAR) |=> (pin_out == ($past(pin_out) & ~$past(w_pin)))); // R4
  AST_DATA_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_DATA) |=> (pin_out == $past(w_pin))); // R2
  AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr != ADDR_DIR) |=> $stable(pin_out)); // R2
  AST_OE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == ADDR_DIR) |=> $stable(pin_oe)); // R5
  AST_NOCLR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_CLR && !HAS_CLEAR) |=> $stable(pin_out)); // R9
  AST_OUTPIN_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_DATA) |-> ((rd_pin & pin_oe) == (pin_out & pin_oe))); // R6
  AST_LATCH_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_SET || bus_addr == ADDR_CLR) |-> (rd_pin == pin_out)); // R10
endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(
  .WIDTH(WIDTH), .DIR_ONE_IS_OUT(DIR_ONE_IS_OUT), .MIRROR(MIRROR), .HAS_CLEAR(HAS_CLEAR)
) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/gpio_port_ctrl_tb_top.sv
module gpio_port_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;

  // Main instance: 32 pins, 1 = output, normal order, clear present
  logic [1:0]  a_addr = '0;
  logic        a_we = 1'b0;
  logic [31:0] a_wdata = '0;
  logic [31:0] a_rdata, a_out, a_oe;
  logic [31:0] a_in = '0;

  // Alternate instance: 8 pins, 1 = input, mirrored, no clear register
  logic [1:0]  b_addr = '0;
  logic        b_we = 1'b0;
  logic [7:0]  b_wdata = '0;
  logic [7:0]  b_rdata, b_out, b_oe;
  logic [7:0]  b_in = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  gpio_port_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(a_addr), .bus_we(a_we), .bus_wdata(a_wdata),
    .bus_rdata(a_rdata), .pin_in(a_in), .pin_out(a_out), .pin_oe(a_oe)
  );

  gpio_port_ctrl #(.WIDTH(8), .DIR_ONE_IS_OUT(1'b0), .MIRROR(1'b1), .HAS_CLEAR(1'b0)) dut_alt_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(b_addr), .bus_we(b_we), .bus_wdata(b_wdata),
    .bus_rdata(b_rdata), .pin_in(b_in), .pin_out(b_out), .pin_oe(b_oe)
  );

  // {address, write data, expected pin_out afterwards}
  localparam logic [65:0] VEC [9] = '{
    {2'd0, 32'hA5A5_0F0F, 32'hA5A5_0F0F},
    {2'd1, 32'h0000_F0F0, 32'hA5A5_FFFF},
    {2'd2, 32'hA5A5_0000, 32'h0000_FFFF},
    {2'd1, 32'h8000_0001, 32'h8000_FFFF},
    {2'd2, 32'h0000_00FF, 32'h8000_FF00},
    {2'd0, 32'h1234_5678, 32'h1234_5678},
    {2'd1, 32'h0000_0000, 32'h1234_5678},
    {2'd2, 32'h0000_0000, 32'h1234_5678},
    {2'd2, 32'hFFFF_FFFF, 32'h0000_0000}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_a(input logic [1:0] ad, input logic [31:0] d);
    a_addr = ad; a_wdata = d; a_we = 1'b1;
    @(posedge clk); @(negedge clk);
    a_we = 1'b0;
  endtask

  task automatic wr_b(input logic [1:0] ad, input logic [7:0] d);
    b_addr = ad; b_wdata = d; b_we = 1'b1;
    @(posedge clk); @(negedge clk);
    b_we = 1'b0;
  endtask

  initial begin
    for (int cyc = 0; cyc < 100000; cyc++) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state, checked while reset is held and after release
    a_addr = 2'd3; b_addr = 2'd3; #1;
    chk("R1 main out", 64'(a_out), 64'h0);
    chk("R1 main oe", 64'(a_oe), 64'h0);
    chk("R1 main dir", 64'(a_rdata), 64'h0);
    chk("R1 alt out", 64'(b_out), 64'h0);
    chk("R1 alt oe", 64'(b_oe), 64'h0);
    chk("R1 alt dir", 64'(b_rdata), 64'hFF);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 make all main pins outputs
    wr_a(2'd3, 32'hFFFF_FFFF);
    chk("R5 main oe all", 64'(a_oe), 64'hFFFF_FFFF);
    a_addr = 2'd3; #1;
    chk("R5 main dir read", 64'(a_rdata), 64'hFFFF_FFFF);

    // Vector table: R2 data, R3 set, R4 clear, R10 latch read, R6 read-back
    for (int k = 0; k < 9; k++) begin
      wr_a(VEC[k][65:64], VEC[k][63:32]);
      chk($sformatf("R2/R3/R4 vec%0d pin_out", k), 64'(a_out), 64'(VEC[k][31:0]));
      a_addr = 2'd1; #1;
      chk($sformatf("R10 vec%0d set read", k), 64'(a_rdata), 64'(VEC[k][31:0]));
      a_addr = 2'd2; #1;
      chk($sformatf("R10 vec%0d clr read", k), 64'(a_rdata), 64'(VEC[k][31:0]));
      a_addr = 2'd0; #1;
      chk($sformatf("R6 vec%0d data read", k), 64'(a_rdata), 64'(VEC[k][31:0]));
    end

    // R5/R6/R7: upper half inputs, input sync latency
    wr_a(2'd3, 32'h0000_FFFF);
    chk("R5 main oe half", 64'(a_oe), 64'h0000_FFFF);
    wr_a(2'd0, 32'h5555_0001);
    a_addr = 2'd0;
    a_in = 32'hABCD_1234;
    @(posedge clk); @(negedge clk);
    chk("R7 one edge old value", 64'(a_rdata), 64'h0000_0001);
    @(posedge clk); @(negedge clk);
    chk("R7 two edges new value", 64'(a_rdata), 64'hABCD_0001);
    chk("R6 inputs not latch", 64'(a_rdata), 64'hABCD_0001);
    chk("R2 latch holds", 64'(a_out), 64'h5555_0001);

    // Alternate instance: R8 mirror, R5 inverted polarity, R9 no clear
    wr_b(2'd0, 8'h01);
    chk("R8 alt data mirrored", 64'(b_out), 64'h80);
    b_addr = 2'd0; #1;
    chk("R6 alt all inputs read", 64'(b_rdata), 64'h00);
    wr_b(2'd3, 8'h0F);
    chk("R5 R8 alt oe", 64'(b_oe), 64'h0F);
    b_addr = 2'd0;
    b_in = 8'h70;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    chk("R6 R8 alt mixed read", 64'(b_rdata), 64'h0E);
    wr_b(2'd1, 8'h3C);
    chk("R9 alt set loads", 64'(b_out), 64'h3C);
    wr_b(2'd2, 8'hFF);
    chk("R9 alt clear ignored", 64'(b_out), 64'h3C);
    b_addr = 2'd2; #1;
    chk("R10 alt clr read", 64'(b_rdata), 64'h3C);
    b_addr = 2'd3; #1;
    chk("R8 alt dir read", 64'(b_rdata), 64'h0F);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule